// File: doc/BRIEF.md
# Stripe Buffer with 4:2:0 Chroma Decimation

This block takes a raster stream of 8-bit RGB pixels and turns each one into a luminance sample and two colour-difference samples. It collects a 16-line stripe of the image. Luminance is kept at full resolution. Each chroma plane is pooled over 2x2 pixel groups, so it holds 8 lines at half width, a quarter of the luminance storage. Every stored sample is 12 bits wide. A later 8x8 transform stage reads the stripe back one 16x16 macroblock at a time, in block order.

A run starts with a one-cycle start pulse. The image width, height and a greyscale flag are captured with that pulse. Pixels enter through a request/valid handshake. When a stripe is full, the block raises a ready flag and stops requesting pixels. The downstream stage then reads the macroblocks and releases the stripe. This repeats until the last line of the image has been released. Width and height must be multiples of 16, and the width must not exceed the `MAX_COLS` parameter.

Top module: `sb_stripe_buf`

## Requirements
- R1: After reset, `busy_o`, `pix_req_o`, `stripe_rdy_o` and `rd_vld_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o` and `pix_req_o` on the next cycle. A `start_i` pulse during a run is ignored: the pixel count and the stripe boundaries are not disturbed.
- R3: In colour mode, luminance is Y = (77R + 150G + 29B + 128) >> 8.
- R4: In colour mode, the per-pixel chroma values are Cb = ((128B − 43R − 85G + 128) >>> 8) + 128 and Cr = ((128R − 107G − 21B + 128) >>> 8) + 128. Each stored chroma sample is (sum of the four values of its 2x2 group + 2) >> 2.
- R5: With `mono_i` high at start, Y equals R, and every chroma sample is 128, whatever G and B are.
- R6: `stripe_rdy_o` rises on the cycle after the 16th line of a stripe is accepted, and not before. While it is high, `pix_req_o` stays low until `stripe_rel_i` is asserted.
- R7: Read position `rd_pos_i` selects a block with bits [8:6] and a row and column within it with bits [5:3] and [2:0]. Blocks 0..3 are the luma quadrants of macroblock `rd_mb_i` (top-left, top-right, bottom-left, bottom-right). Block 4 is Cb and block 5 is Cr.
- R8: `rd_vld_o` is high exactly one cycle after each `rd_en_i`, and `rd_data_o` carries the addressed sample in that cycle.
- R9: Releasing a stripe resumes pixel requests if image lines remain. Releasing the stripe that holds the last line drops `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle run start |
| width_i | input | COL_W | Image columns, captured at start |
| height_i | input | LIN_W | Image lines, captured at start |
| mono_i | input | 1 | Greyscale input flag, captured at start |
| busy_o | output | 1 | Run in progress |
| pix_req_o | output | 1 | Block can take a pixel |
| pix_vld_i | input | 1 | Pixel present on the colour inputs |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| stripe_rdy_o | output | 1 | Stripe complete and held for reading |
| stripe_rel_i | input | 1 | Downstream frees the stripe |
| rd_en_i | input | 1 | Read request |
| rd_mb_i | input | MB_W | Macroblock column index |
| rd_pos_i | input | 9 | Block-ordered position within the macroblock |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 12 | 12-bit sample |

## Verification
The first image is 32x32 in colour, built from coordinate-mixed patterns in which R, G and B all differ. It is sent with periodic gaps in `pix_vld_i` and with a stray start pulse mid-stripe. Reading every position of both macroblocks in both stripes separates luma quadrant ordering from chroma plane ordering. The uneven 2x2 groups also expose rounding and line-pairing errors in the pooling. The second image is 16x16 in greyscale mode with unequal R, G and B. This shows that G and B are ignored and that the chroma is fixed. Both images end on a release, which tells the multi-stripe path apart from the single-stripe path.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SAMP_W = 12;
  typedef logic [SAMP_W-1:0] samp_t;
  typedef struct packed {
    samp_t y;
    samp_t cb;
    samp_t cr;
  } ycc_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_HOLD} st_e;
endpackage

// File: rtl/sb_color_conv.sv
module sb_color_conv
  import sb_pkg::*;
(
  input  logic [7:0] r_i,
  input  logic [7:0] g_i,
  input  logic [7:0] b_i,
  input  logic       mono_i,
  output ycc_t       ycc_o
);
  logic [16:0]        y_sum;
  logic signed [18:0] rs, gs, bs, cb_sum, cr_sum, cb_q, cr_q;

  always_comb begin
    rs = $signed({11'd0, r_i});
    gs = $signed({11'd0, g_i});
    bs = $signed({11'd0, b_i});
    y_sum  = 17'd77 * 17'(r_i) + 17'd150 * 17'(g_i) + 17'd29 * 17'(b_i) + 17'd128;
    cb_sum = 19'sd128 * bs - 19'sd43 * rs - 19'sd85 * gs + 19'sd128;
    cr_sum = 19'sd128 * rs - 19'sd107 * gs - 19'sd21 * bs + 19'sd128;
    cb_q   = (cb_sum >>> 8) + 19'sd128;
    cr_q   = (cr_sum >>> 8) + 19'sd128;
    if (mono_i) begin
      ycc_o.y  = {4'd0, r_i};
      ycc_o.cb = 12'd128;
      ycc_o.cr = 12'd128;
    end else begin
      ycc_o.y  = {4'd0, y_sum[15:8]};
      ycc_o.cb = cb_q[11:0];
      ycc_o.cr = cr_q[11:0];
    end
  end
endmodule

// File: rtl/sb_chroma_pool.sv
module sb_chroma_pool
  import sb_pkg::*;
#(
  parameter int HALF  = 64,
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acc_i,
  input  logic                   odd_col_i,
  input  logic                   odd_line_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [1:0][SAMP_W-1:0] in_i,
  output logic                   wr_o,
  output logic [1:0][SAMP_W-1:0] out_o
);
  assign wr_o = acc_i & odd_col_i & odd_line_i;

  for (genvar p = 0; p < 2; p++) begin : g_plane
    samp_t hold_q;
    samp_t acc_q [HALF];
    samp_t pair, tot;

    always_comb begin
      pair      = hold_q + in_i[p];
      tot       = acc_q[idx_i] + pair + 12'd2;
      out_o[p]  = tot >> 2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  hold_q <= '0;
      else if (acc_i && !odd_col_i) hold_q <= in_i[p];
    end

    always_ff @(posedge clk_i) begin
      if (acc_i && odd_col_i && !odd_line_i) acc_q[idx_i] <= pair;
    end

    // pooled sample never exceeds the largest converted value
    p_avg_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_o |-> (out_o[p] <= 12'd256));
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH = 256,
  parameter int W     = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sb_stripe_buf.sv
module sb_stripe_buf
  import sb_pkg::*;
#(
  parameter int MAX_COLS = 128,
  parameter int LIN_W    = 9,
  localparam int COL_W   = $clog2(MAX_COLS) + 1,
  localparam int HALF    = MAX_COLS / 2,
  localparam int LDEPTH  = MAX_COLS * 16,
  localparam int CDEPTH  = MAX_COLS * 4,
  localparam int LA_W    = $clog2(LDEPTH),
  localparam int CA_W    = $clog2(CDEPTH),
  localparam int HX_W    = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int MB_W    = (MAX_COLS > 16) ? $clog2(MAX_COLS / 16) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  width_i,
  input  logic [LIN_W-1:0]  height_i,
  input  logic              mono_i,
  output logic              busy_o,
  output logic              pix_req_o,
  input  logic              pix_vld_i,
  input  logic [7:0]        red_i,
  input  logic [7:0]        green_i,
  input  logic [7:0]        blue_i,
  output logic              stripe_rdy_o,
  input  logic              stripe_rel_i,
  input  logic              rd_en_i,
  input  logic [MB_W-1:0]   rd_mb_i,
  input  logic [8:0]        rd_pos_i,
  output logic              rd_vld_o,
  output logic [SAMP_W-1:0] rd_data_o
);
  st_e              state_q;
  logic [COL_W-1:0] col_q, width_q;
  logic [3:0]       sline_q;
  logic [LIN_W-1:0] aline_q, height_q;
  logic             mono_q;
  logic             accept, line_end;
  ycc_t             ycc;

  assign busy_o       = (state_q != ST_IDLE);
  assign pix_req_o    = (state_q == ST_FILL);
  assign stripe_rdy_o = (state_q == ST_HOLD);
  assign accept       = pix_req_o & pix_vld_i;
  assign line_end     = (col_q == width_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      col_q    <= '0;
      sline_q  <= '0;
      aline_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      mono_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_FILL;
          width_q  <= width_i;
          height_q <= height_i;
          mono_q   <= mono_i;
          col_q    <= '0;
          sline_q  <= '0;
          aline_q  <= '0;
        end
        ST_FILL: if (accept) begin
          if (line_end) begin
            col_q   <= '0;
            sline_q <= sline_q + 4'd1;
            aline_q <= aline_q + 1'b1;
            if (sline_q == 4'd15) state_q <= ST_HOLD;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_HOLD: if (stripe_rel_i) state_q <= (aline_q == height_q) ? ST_IDLE : ST_FILL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sb_color_conv u_conv (
    .r_i    (red_i),
    .g_i    (green_i),
    .b_i    (blue_i),
    .mono_i (mono_q),
    .ycc_o  (ycc)
  );

  // chroma pooling over 2x2 groups
  logic                   c_wr;
  logic [1:0][SAMP_W-1:0] c_in, c_wdata;
  assign c_in[0] = ycc.cb;
  assign c_in[1] = ycc.cr;

  sb_chroma_pool #(.HALF(HALF)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (accept),
    .odd_col_i  (col_q[0]),
    .odd_line_i (sline_q[0]),
    .idx_i      (HX_W'(col_q >> 1)),
    .in_i       (c_in),
    .wr_o       (c_wr),
    .out_o      (c_wdata)
  );

  // write addressing
  logic [LA_W-1:0] l_waddr, l_raddr;
  logic [CA_W-1:0] c_waddr, c_raddr;
  logic [2:0]      blk, blk_q;
  assign blk     = rd_pos_i[8:6];
  assign l_waddr = LA_W'(sline_q) * LA_W'(MAX_COLS) + LA_W'(col_q);
  assign c_waddr = CA_W'(sline_q[3:1]) * CA_W'(HALF) + CA_W'(col_q >> 1);

  // block-ordered read addressing: quadrant bits pick row half and column half
  assign l_raddr = LA_W'({blk[1], rd_pos_i[5:3]}) * LA_W'(MAX_COLS)
                 + LA_W'({rd_mb_i, blk[0], rd_pos_i[2:0]});
  assign c_raddr = CA_W'(rd_pos_i[5:3]) * CA_W'(HALF) + CA_W'({rd_mb_i, rd_pos_i[2:0]});

  samp_t y_rd;
  samp_t c_rd [2];

  sb_store #(.DEPTH(LDEPTH), .W(SAMP_W)) u_luma (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (l_waddr),
    .wdata_i (ycc.y),
    .re_i    (rd_en_i),
    .raddr_i (l_raddr),
    .rdata_o (y_rd)
  );

  for (genvar p = 0; p < 2; p++) begin : g_cstore
    sb_store #(.DEPTH(CDEPTH), .W(SAMP_W)) u_chroma (
      .clk_i   (clk_i),
      .we_i    (c_wr),
      .waddr_i (c_waddr),
      .wdata_i (c_wdata[p]),
      .re_i    (rd_en_i),
      .raddr_i (c_raddr),
      .rdata_o (c_rd[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o <= 1'b0;
      blk_q    <= '0;
    end else begin
      rd_vld_o <= rd_en_i;
      if (rd_en_i) blk_q <= blk;
    end
  end

  always_comb begin
    if (!blk_q[2])          rd_data_o = y_rd;
    else if (blk_q == 3'd4) rd_data_o = c_rd[0];
    else if (blk_q == 3'd5) rd_data_o = c_rd[1];
    else                    rd_data_o = '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!pix_req_o && !stripe_rdy_o));
  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_req_o && start_i && !pix_vld_i) |=> ($stable(col_q) && pix_req_o));
  p_mono_chroma_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && mono_q) |-> (c_wdata[0] == 12'd128 && c_wdata[1] == 12'd128));
  p_hold_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stripe_rdy_o |-> !pix_req_o);
  p_rdy_after_pixel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stripe_rdy_o) |-> $past(pix_vld_i && pix_req_o));
  p_rd_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_vld_o);
  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(stripe_rel_i && stripe_rdy_o));
endmodule

// File: tb/sim_sb_stripe_buf.sv
module sim_sb_stripe_buf;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  width = '0;
  logic [8:0]  height = '0;
  logic        mono = 1'b0;
  logic        busy, pix_req, stripe_rdy, rd_vld;
  logic        pix_vld = 1'b0;
  logic [7:0]  red = '0, green = '0, blue = '0;
  logic        stripe_rel = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_mb = '0;
  logic [8:0]  rd_pos = '0;
  logic [11:0] rd_data;

  int total = 0;
  int bad = 0;
  int q_exp[$];
  int q_tag[$];
  int ey [16][MAXC];
  int ecb[16][MAXC];
  int ecr[16][MAXC];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sb_stripe_buf #(.MAX_COLS(MAXC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .width_i(width), .height_i(height),
    .mono_i(mono), .busy_o(busy), .pix_req_o(pix_req), .pix_vld_i(pix_vld),
    .red_i(red), .green_i(green), .blue_i(blue), .stripe_rdy_o(stripe_rdy),
    .stripe_rel_i(stripe_rel), .rd_en_i(rd_en), .rd_mb_i(rd_mb), .rd_pos_i(rd_pos),
    .rd_vld_o(rd_vld), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected samples as read data appears
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R8 unexpected rd_vld_o", int'(rd_data), -1);
      end else begin
        int e, t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (t == 3)      chk(int'(rd_data) == e, "R3/R7 luma sample", int'(rd_data), e);
        else if (t == 4) chk(int'(rd_data) == e, "R4/R7 chroma sample", int'(rd_data), e);
        else             chk(int'(rd_data) == e, "R5 mono sample", int'(rd_data), e);
      end
    end
  end

  task automatic feed_stripe(input int w, input int row0, input int seed, input bit mb,
                             input bit poke);
    for (int k = 0; k < 16 * w; k++) begin
      int x, ly, y, r, g, b;
      x = k % w; ly = k / w; y = row0 + ly;
      r = (x * 37 + y * 11 + seed) & 255;
      g = (x * 5 + y * 53 + 3 * seed) & 255;
      b = (x * x + y * 29 + 7 * seed) & 255;
      if (mb) begin
        ey[ly][x] = r; ecb[ly][x] = 128; ecr[ly][x] = 128;
      end else begin
        ey[ly][x]  = (77 * r + 150 * g + 29 * b + 128) >>> 8;
        ecb[ly][x] = ((128 * b - 43 * r - 85 * g + 128) >>> 8) + 128;
        ecr[ly][x] = ((128 * r - 107 * g - 21 * b + 128) >>> 8) + 128;
      end
      @(negedge clk);
      start = 1'b0;
      if ((k % 7) == 3) begin
        pix_vld = 1'b0;
        @(negedge clk);
      end
      while (!pix_req) @(negedge clk);
      if (k == 16 * w - 1) chk(stripe_rdy == 1'b0, "R6 early stripe_rdy_o", int'(stripe_rdy), 0);
      red = 8'(r); green = 8'(g); blue = 8'(b);
      pix_vld = 1'b1;
      start = poke && (k == 20);
      @(posedge clk);
    end
    @(negedge clk);
    pix_vld = 1'b0;
    start = 1'b0;
    chk(stripe_rdy == 1'b1, "R6 stripe_rdy_o after 16 lines", int'(stripe_rdy), 1);
    chk(pix_req == 1'b0, "R6 pix_req_o low when full", int'(pix_req), 0);
    repeat (5) begin
      @(negedge clk);
      chk(pix_req == 1'b0 && stripe_rdy == 1'b1, "R6 stall held", int'(pix_req), 0);
    end
  endtask

  task automatic read_stripe(input int w, input bit mb);
    for (int m = 0; m < w / 16; m++) begin
      for (int p = 0; p < 384; p++) begin
        int blk, rr, cc, e, cx, cs;
        blk = p / 64; rr = (p / 8) % 8; cc = p % 8;
        if (blk < 4) begin
          e = ey[(blk / 2) * 8 + rr][m * 16 + (blk % 2) * 8 + cc];
        end else begin
          cx = m * 8 + cc;
          if (blk == 4)
            cs = ecb[2*rr][2*cx] + ecb[2*rr][2*cx+1] + ecb[2*rr+1][2*cx] + ecb[2*rr+1][2*cx+1];
          else
            cs = ecr[2*rr][2*cx] + ecr[2*rr][2*cx+1] + ecr[2*rr+1][2*cx] + ecr[2*rr+1][2*cx+1];
          e = (cs + 2) >> 2;
        end
        @(negedge clk);
        rd_en = 1'b1; rd_mb = 3'(m); rd_pos = 9'(p);
        q_exp.push_back(e);
        q_tag.push_back(mb ? 5 : (blk < 4 ? 3 : 4));
      end
    end
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk(rd_vld == 1'b0, "R8 rd_vld_o drops after reads", int'(rd_vld), 0);
    chk(q_exp.size() == 0, "R8 all reads returned", q_exp.size(), 0);
  endtask

  task automatic release_stripe(input bit last);
    @(negedge clk);
    stripe_rel = 1'b1;
    @(negedge clk);
    stripe_rel = 1'b0;
    chk(stripe_rdy == 1'b0, "R9 stripe_rdy_o cleared", int'(stripe_rdy), 0);
    chk(busy == !last, "R9 busy_o after release", int'(busy), int'(!last));
    chk(pix_req == !last, "R9 pix_req_o after release", int'(pix_req), int'(!last));
  endtask

  task automatic start_run(input int w, input int h, input bit mb);
    @(negedge clk);
    width = 8'(w); height = 9'(h); mono = mb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy_o after start", int'(busy), 1);
    chk(pix_req == 1'b1, "R2 pix_req_o after start", int'(pix_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && pix_req == 1'b0, "R1 reset busy/req", int'(busy), 0);
    chk(stripe_rdy == 1'b0 && rd_vld == 1'b0, "R1 reset rdy/vld", int'(stripe_rdy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // 32x32 colour, stray start mid-stripe (R2)
    start_run(32, 32, 1'b0);
    feed_stripe(32, 0, 1, 1'b0, 1'b1);
    read_stripe(32, 1'b0);
    release_stripe(1'b0);
    feed_stripe(32, 16, 9, 1'b0, 1'b0);
    read_stripe(32, 1'b0);
    release_stripe(1'b1);
    // 16x16 greyscale with unequal G and B (R5)
    start_run(16, 16, 1'b1);
    feed_stripe(16, 0, 4, 1'b1, 1'b0);
    read_stripe(16, 1'b1);
    release_stripe(1'b1);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule